// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog timer for a system that must be brought back if software stops making progress. Software enables the counter and picks a timeout code in a mode register. It then restarts the count at intervals by writing a control register. A restart only counts when the written value carries a 12-bit key, so a stray store cannot keep a dead system alive. If the count runs out, the block either raises a sticky interrupt or sends a fixed-width reset request, depending on a configuration register.

Time is counted in half-second ticks from a prescaler of `TICK_CLKS` core clocks. A simulation can set this parameter small. Timeout codes map to intervals that are not linear. The controlling state machine has three states. In ST_OFF the counter is held. In ST_RUN the count goes down. In ST_RST the reset request is held high. The state machine has these transitions:

- START: ST_OFF to ST_RUN, on a mode write with the enable bit set. It loads the interval of the written code.
- STOP: ST_RUN or ST_RST to ST_OFF, on a mode write with the enable bit clear.
- FIRE: ST_RUN to ST_RST, on expiry with the reset action.
- RESUME: ST_RST to ST_RUN, or to ST_OFF if the stored enable is clear, after `RST_CLKS` clocks.

An expiry with the interrupt action stays in ST_RUN and reloads the count.

Top module: `kwd_top`

## Requirements
- R1: After reset, `irq` and `rst_req` are low, and the mode register (0x18) and the configuration register (0x14) read zero.
- R2: A write to the control register (0x10) restarts the count from the full interval of the stored code only when bit 0 is 1 and bits 12:1 equal 0xA57 (data bits 12:0 = 0x14AF; higher bits are don't-care). Any other control write leaves the expiry time unchanged.
- R3: Timeout code (mode bits 7:4) to interval, in half-second ticks: 0 gives 1; codes 1 to 6 give 2×code; codes 7, 8, 9 and 10 give 16, 20, 24 and 28; codes 11 to 15 give 32. Expiry falls exactly interval×`TICK_CLKS` clocks after the edge that loads the count.
- R4: A mode write that keeps the enable bit set but changes the code does not alter the running count. The next keyed restart uses the new code.
- R5: A mode write with bit 0 set while the timer is disabled loads the interval of the code in that same write and starts counting.
- R6: A mode write with bit 0 clear stops the timer. No interrupt and no reset request occur while it is stopped.
- R7: With configuration bits 1:0 = 01, expiry drives `rst_req` high for exactly 4 consecutive clocks (`RST_CLKS`).
- R8: With any other configuration value, expiry sets a sticky status bit (configuration bit 4) that drives `irq`. Writing 1 to configuration bit 4 clears it, and writing 0 there leaves it set.
- R9: The mode register reads back the stored bits 7:4 and bit 0. The configuration register reads back bits 1:0 and the status in bit 4. The control register always reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wen | input | 1 | Single-cycle write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Sticky expiry interrupt |
| rst_req | output | 1 | System reset request pulse |

## Verification
The hardest states to reach are those where two events meet in time. One is a keyed restart or a code change landing partway through a running count, and the bench must show that only the first moves the expiry. The other is a stop landing a cycle before the count would run out. The bench reaches them with directed sequences and times every expiry in clocks from the loading write. It then repeats enable-and-wait rounds with codes and actions drawn from a seeded generator, so that every code and both actions are compared against a bench-side interval table.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int CNT_W     = 6;
    localparam int OFS_CTRL  = 'h10;
    localparam int OFS_CFG   = 'h14;
    localparam int OFS_MODE  = 'h18;
    localparam logic [11:0] KEY_VAL = 12'hA57;
    localparam logic [12:0] RELOAD_WORD = {KEY_VAL, 1'b1};
    localparam int STAT_BIT  = 4;
    localparam int CODE_LSB  = 4;
    localparam logic [1:0] ACT_RESET = 2'b01;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_RUN = 2'd1,
        ST_RST = 2'd2
    } wd_state_t;

    function automatic logic [CNT_W-1:0] ticks_for(input logic [3:0] code);
        logic [CNT_W-1:0] t;
        if (code == 4'd0)
            t = 6'd1;
        else if (code <= 4'd6)
            t = {1'b0, code, 1'b0};
        else if (code <= 4'd10)
            t = {code - 4'd3, 2'b00};
        else
            t = 6'd32;
        return t;
    endfunction

endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_set,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        act,
    output logic              stat,
    output logic              mode_en,
    output logic [3:0]        code,
    output logic              mode_wr,
    output logic              reload_hit
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);

    logic cfg_wr;
    logic unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:13];

    always_comb begin
        cfg_wr     = wen && (addr == A_CFG);
        mode_wr    = wen && (addr == A_MODE);
        reload_hit = wen && (addr == A_CTRL) && (wdata[12:0] == RELOAD_WORD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act     <= 2'b00;
            stat    <= 1'b0;
            mode_en <= 1'b0;
            code    <= 4'd0;
        end else begin
            if (cfg_wr)
                act <= wdata[1:0];
            if (irq_set)
                stat <= 1'b1;
            else if (cfg_wr && wdata[STAT_BIT])
                stat <= 1'b0;
            if (mode_wr) begin
                mode_en <= wdata[0];
                code    <= wdata[CODE_LSB +: 4];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CFG) begin
            rdata[1:0]      = act;
            rdata[STAT_BIT] = stat;
        end else if (addr == A_MODE) begin
            rdata[0]             = mode_en;
            rdata[CODE_LSB +: 4] = code;
        end
    end

endmodule

// File: rtl/kwd_tick.sv
module kwd_tick #(
    parameter int TICK_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);

    localparam int PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CLKS - 1);

    logic [PW-1:0] pre;

    assign tick = run && !clr && (pre == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre <= '0;
        else if (clr || tick)
            pre <= '0;
        else if (run)
            pre <= pre + 1'b1;
    end

endmodule

// File: rtl/kwd_fsm.sv
module kwd_fsm
    import kwd_pkg::*;
#(
    parameter int RST_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic             wr_en_bit,
    input  logic [3:0]       wr_code,
    input  logic [3:0]       code_q,
    input  logic             mode_en,
    input  logic             reload_hit,
    input  logic [1:0]       act,
    input  logic             tick,
    output wd_state_t        st,
    output logic [CNT_W-1:0] cnt,
    output logic             rst_req,
    output logic             irq_set,
    output logic             pre_clr,
    output logic             pre_run
);

    localparam int PC_W = (RST_CLKS > 1) ? $clog2(RST_CLKS) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(RST_CLKS - 1);

    wd_state_t       nxt;
    logic [PC_W-1:0] pc;
    logic            expire;
    logic            start;
    logic            stop;

    assign expire = (st == ST_RUN) && tick && (cnt == 6'd1);
    assign start  = mode_wr && wr_en_bit;
    assign stop   = mode_wr && !wr_en_bit;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_OFF: if (start) nxt = ST_RUN;
            ST_RUN: begin
                if (stop)
                    nxt = ST_OFF;
                else if (expire && act == ACT_RESET)
                    nxt = ST_RST;
            end
            ST_RST: begin
                if (stop)
                    nxt = ST_OFF;
                else if (pc == PC_LAST)
                    nxt = mode_en ? ST_RUN : ST_OFF;
            end
            default: nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_OFF;
        else
            st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            pc  <= '0;
        end else begin
            pc <= (st == ST_RST && nxt == ST_RST) ? pc + 1'b1 : '0;
            if (st == ST_OFF && start)
                cnt <= ticks_for(wr_code);
            else if (st == ST_RUN && !stop) begin
                if (reload_hit)
                    cnt <= ticks_for(code_q);
                else if (tick)
                    cnt <= (cnt == 6'd1) ? ticks_for(code_q) : cnt - 1'b1;
            end
        end
    end

    always_comb begin
        rst_req = (st == ST_RST);
        irq_set = expire && (act != ACT_RESET);
        pre_run = (st == ST_RUN);
        pre_clr = (st == ST_OFF && start) || (st == ST_RUN && reload_hit);
    end

endmodule

// File: rtl/kwd_top.sv
module kwd_top
    import kwd_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int TICK_CLKS = 16,
    parameter int RST_CLKS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);

    logic [1:0]       act_w;
    logic             stat_w;
    logic             en_w;
    logic [3:0]       code_w;
    logic             mode_wr_w;
    logic             reload_w;
    logic             irq_set_w;
    logic             tick_w;
    logic             pre_clr_w;
    logic             pre_run_w;
    wd_state_t        st_w;
    logic [CNT_W-1:0] cnt_w;

    kwd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wen        (bus_wen),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .irq_set    (irq_set_w),
        .rdata      (bus_rdata),
        .act        (act_w),
        .stat       (stat_w),
        .mode_en    (en_w),
        .code       (code_w),
        .mode_wr    (mode_wr_w),
        .reload_hit (reload_w)
    );

    kwd_tick #(.TICK_CLKS(TICK_CLKS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pre_run_w),
        .clr   (pre_clr_w),
        .tick  (tick_w)
    );

    kwd_fsm #(.RST_CLKS(RST_CLKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr_w),
        .wr_en_bit  (bus_wdata[0]),
        .wr_code    (bus_wdata[CODE_LSB +: 4]),
        .code_q     (code_w),
        .mode_en    (en_w),
        .reload_hit (reload_w),
        .act        (act_w),
        .tick       (tick_w),
        .st         (st_w),
        .cnt        (cnt_w),
        .rst_req    (rst_req),
        .irq_set    (irq_set_w),
        .pre_clr    (pre_clr_w),
        .pre_run    (pre_run_w)
    );

    assign irq = stat_w;

endmodule

// File: rtl/kwd_chk.sv
module kwd_chk
    import kwd_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int RST_CLKS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wen,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic              rst_req,
    input wd_state_t         st,
    input logic [CNT_W-1:0]  cnt,
    input logic [3:0]        code_q,
    input logic              tick
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);

    logic [7:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_len <= '0;
        else
            hi_len <= rst_req ? hi_len + 8'd1 : 8'd0;
    end

    AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && wen && addr == A_CTRL && wdata[12:0] != RELOAD_WORD && !tick)
        |=> cnt == $past(cnt)); // R2

    AST_KEY_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && wen && addr == A_CTRL && wdata[12:0] == RELOAD_WORD)
        |=> cnt == ticks_for($past(code_q))); // R2

    AST_RST_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> hi_len < 8'(RST_CLKS)); // R7

    AST_RST_FULL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && hi_len != 8'd0 && st != ST_OFF) |-> hi_len == 8'(RST_CLKS)); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wen && addr == A_CFG && wdata[STAT_BIT])) |=> irq); // R8

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF) |=> !$rose(irq) && !$rose(rst_req)); // R6

    AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CTRL) |-> rdata == '0); // R9

endmodule

bind kwd_top kwd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_CLKS(RST_CLKS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wen     (bus_wen),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .irq     (irq),
    .rst_req (rst_req),
    .st      (st_w),
    .cnt     (cnt_w),
    .code_q  (code_w),
    .tick    (tick_w)
);

// File: tb/sim_kwd_top.sv
`timescale 1ns/1ps
module sim_kwd_top;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int TK = 3;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wen = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;
    logic          rst_req;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    kwd_top #(.ADDR_W(AW), .DATA_W(DW), .TICK_CLKS(TK), .RST_CLKS(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    function automatic int exp_ticks(input int code);
        case (code)
            0: return 1;
            1, 2, 3, 4, 5, 6: return 2 * code;
            7: return 16;
            8: return 20;
            9: return 24;
            10: return 28;
            default: return 32;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_evt(input bit sel_rst, input int t0, output int d);
        int n = 0;
        while (!(sel_rst ? rst_req : irq) && n < 400) begin
            @(negedge clk);
            n++;
        end
        d = cyc - t0;
    endtask

    task automatic pulse_width(output int w);
        w = 0;
        while (rst_req && w < 20) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic arm(input int code, input int act, output int t0);
        wr(8'h18, 32'h0);
        wr(8'h14, 32'h10 | act);
        wr(8'h18, (code << 4) | 1);
        t0 = cyc;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int t0, tr, d, w;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(rst_req == 1'b0, "R1 rst_req", rst_req, 0);
        rd(8'h18, r); check(r == 0, "R1 mode", r, 0);
        rd(8'h14, r); check(r == 0, "R1 cfg", r, 0);

        // R9 readback
        wr(8'h18, 32'hFFFF_FFF0);
        rd(8'h18, r); check(r == 32'hF0, "R9 mode", r, 32'hF0);
        wr(8'h14, 32'h0000_0003);
        rd(8'h14, r); check(r == 32'h3, "R9 cfg", r, 3);
        wr(8'h10, 32'h0000_14AF);
        rd(8'h10, r); check(r == 0, "R9 ctrl", r, 0);
        wr(8'h14, 32'h0);

        // R3 R5 shortest code, interrupt action
        arm(0, 0, t0); wait_evt(0, t0, d);
        check(d == TK, "R3 R5 code0", d, TK);

        // R8 sticky status and clear
        wr(8'h18, 32'h0);
        wr(8'h14, 32'h0);
        check(irq == 1'b1, "R8 sticky irq", irq, 1);
        rd(8'h14, r); check(r == 32'h10, "R8 status bit", r, 32'h10);
        wr(8'h14, 32'h10);
        check(irq == 1'b0, "R8 clear irq", irq, 0);

        // R4 code change alone does not restart
        arm(1, 0, t0);
        wr(8'h18, 32'hB1);
        wait_evt(0, t0, d);
        check(d == 2 * TK, "R4 code change", d, 2 * TK);

        // R4 R2 keyed restart after code change uses new code
        arm(1, 0, t0);
        wr(8'h18, 32'h21);
        wr(8'h10, 32'h0000_14AF);
        tr = cyc;
        wait_evt(0, tr, d);
        check(d == 4 * TK, "R4 new code after reload", d, 4 * TK);

        // R2 wrong writes to control ignored
        arm(2, 0, t0);
        wr(8'h10, 32'h0000_14AE);
        wr(8'h10, 32'h0000_14AD);
        wr(8'h10, 32'h0000_0001);
        wait_evt(0, t0, d);
        check(d == 4 * TK, "R2 bad key ignored", d, 4 * TK);

        // R2 valid key (upper bits set) restarts
        arm(2, 0, t0);
        repeat (4) @(negedge clk);
        wr(8'h10, 32'hFFFF_14AF);
        tr = cyc;
        wait_evt(0, tr, d);
        check(d == 4 * TK, "R2 good key", d, 4 * TK);

        // R7 reset action
        arm(3, 1, t0);
        wait_evt(1, t0, d);
        check(d == 6 * TK, "R7 reset timing", d, 6 * TK);
        pulse_width(w);
        check(w == RW, "R7 pulse width", w, RW);
        check(irq == 1'b0, "R7 no irq", irq, 0);

        // R6 stop before expiry
        arm(0, 0, t0);
        wr(8'h18, 32'h0);
        repeat (100) @(negedge clk);
        check(irq == 1'b0, "R6 stopped irq", irq, 0);
        arm(0, 1, t0);
        wr(8'h18, 32'h0);
        w = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (rst_req) w++;
        end
        check(w == 0, "R6 stopped rst_req", w, 0);

        // R3 R7 R8 random rounds
        for (int i = 0; i < 24; i++) begin
            int code, act;
            code = int'($urandom % 16);
            act = int'($urandom % 4);
            arm(code, act, t0);
            wait_evt(act == 1, t0, d);
            check(d == exp_ticks(code) * TK, "R3 random interval", d, exp_ticks(code) * TK);
            if (act == 1) begin
                pulse_width(w);
                check(w == RW, "R7 random width", w, RW);
            end else begin
                check(irq == 1'b1, "R8 random irq", irq, 1);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule